// File: doc/BRIEF.md
# Register-Group ALU for a Retro Virtual Machine

This block is a combinational arithmetic and logic unit for the register-to-register instruction group of a small retro virtual machine. It takes two operands, `x` and `y`, a three-bit operation code and a swap control. It returns a result of the same width as the operands and a single flag bit. The CPU writes that flag into its flag register. Each operation gives the flag its own meaning: the carry out of an addition, "no borrow" after a subtraction, the bit pushed out by a shift, or zero for the pass and bitwise operations.

One subtractor serves both subtract directions. When the swap control is high during a subtract, the operands trade places before they reach the subtractor, so the result is `y - x` in place of `x - y`. Instruction decoding, register-file reads and the flag write-back all sit outside this block. The block holds no state and has no clock. Its outputs follow its inputs in the same time step.

Top module: `vm_reg_alu`

## Requirements
- R1: Operation code 0 (copy) drives `y` onto the result, and the flag is 0.
- R2: Operation codes 1, 2 and 3 give the bitwise OR, AND and XOR of `x` and `y` in that order, and the flag is 0 for each of them.
- R3: Operation code 4 (add) gives `(x + y) mod 2^WIDTH`, and the flag is the carry out of the top bit. For example, 0xFF + 0x01 gives 0x00 with the flag at 1.
- R4: Operation code 5 (subtract) with `swap_i` at 0 gives `(x - y) mod 2^WIDTH`, and the flag is 1 exactly when `x >= y`, that is, when no borrow occurs.
- R5: Operation code 5 with `swap_i` at 1 gives `(y - x) mod 2^WIDTH`, and the flag is 1 exactly when `y >= x`.
- R6: Operation code 6 shifts `x` right by one place and puts 0 in the top bit. The flag is the old bit 0 of `x`.
- R7: Operation code 7 shifts `x` left by one place and puts 0 in bit 0. The flag is the old top bit of `x`.
- R8: For every operation code other than 5, `swap_i` has no effect on either the result or the flag.
- R9: Result and flag are a pure function of the present inputs and settle in the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand (`x`) |
| y_i | input | WIDTH | Second operand (`y`) |
| op_i | input | 3 | Operation code, 0 to 7 |
| swap_i | input | 1 | Exchanges the operands when the operation is a subtract |
| res_o | output | WIDTH | Result |
| flag_o | output | 1 | Carry, no-borrow, shifted-out bit, or 0, depending on the operation |

## Verification
The bench builds the block at the default `WIDTH = 8`. At that width, the edge operands 0x00, 0x01, 0x7F, 0x80, 0xFE and 0xFF can be combined exhaustively with every operation code and both swap settings. This covers the wraparound corners of the adder and the subtractor, and the equal-operand case in which subtract must report no borrow. Because the width is eight, the top-bit flag of a left shift is bit 7, and the tests can reach it with plain byte patterns such as 0x80 and 0x55/0xAA.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

  typedef enum logic [2:0] {
    OP_COPY = 3'd0,
    OP_OR   = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_ADD  = 3'd4,
    OP_SUB  = 3'd5,
    OP_SHR  = 3'd6,
    OP_SHL  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_LOGIC = 2'd0,
    SEL_ARITH = 2'd1,
    SEL_SHIFT = 2'd2
  } unit_sel_e;

endpackage

// File: rtl/vm_alu_logic.sv
module vm_alu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fn_i,
  output logic [WIDTH-1:0] res_o
);

  // One bit slice per operand bit: copy, OR, AND, XOR selected by fn_i
  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    always_comb begin
      unique case (fn_i)
        2'd0:    res_o[g] = b_i[g];
        2'd1:    res_o[g] = a_i[g] | b_i[g];
        2'd2:    res_o[g] = a_i[g] & b_i[g];
        default: res_o[g] = a_i[g] ^ b_i[g];
      endcase
    end
  end

endmodule

// File: rtl/vm_alu_addsub.sv
module vm_alu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic [SUM_W-1:0] sum;

  // Subtract as a + ~b + 1; the carry out is then the no-borrow indication
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  end

  assign res_o  = sum[WIDTH-1:0];
  assign cout_o = sum[WIDTH];

endmodule

// File: rtl/vm_alu_shift.sv
module vm_alu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             left_i,
  output logic [WIDTH-1:0] res_o,
  output logic             out_bit_o
);

  always_comb begin
    if (left_i) begin
      res_o     = {a_i[WIDTH-2:0], 1'b0};
      out_bit_o = a_i[WIDTH-1];
    end else begin
      res_o     = {1'b0, a_i[WIDTH-1:1]};
      out_bit_o = a_i[0];
    end
  end

endmodule

// File: rtl/vm_reg_alu.sv
module vm_reg_alu
  import vm_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [2:0]       op_i,
  input  logic             swap_i,
  output logic [WIDTH-1:0] res_o,
  output logic             flag_o
);

  alu_op_e          op;
  unit_sel_e        sel;
  logic             is_sub;
  logic             do_swap;
  logic [WIDTH-1:0] opa;
  logic [WIDTH-1:0] opb;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] arith_res;
  logic             arith_cout;
  logic [WIDTH-1:0] shift_res;
  logic             shift_bit;

  assign op      = alu_op_e'(op_i);
  assign is_sub  = (op == OP_SUB);
  // Operand exchange only takes effect for subtract
  assign do_swap = is_sub & swap_i;
  assign opa     = do_swap ? y_i : x_i;
  assign opb     = do_swap ? x_i : y_i;

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: sel = SEL_ARITH;
      OP_SHR, OP_SHL: sel = SEL_SHIFT;
      default:        sel = SEL_LOGIC;
    endcase
  end

  vm_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (x_i),
    .b_i   (y_i),
    .fn_i  (op_i[1:0]),
    .res_o (logic_res)
  );

  vm_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (opa),
    .b_i    (opb),
    .sub_i  (is_sub),
    .res_o  (arith_res),
    .cout_o (arith_cout)
  );

  vm_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i       (x_i),
    .left_i    (op_i[0]),
    .res_o     (shift_res),
    .out_bit_o (shift_bit)
  );

  always_comb begin
    unique case (sel)
      SEL_ARITH: begin
        res_o  = arith_res;
        flag_o = arith_cout;
      end
      SEL_SHIFT: begin
        res_o  = shift_res;
        flag_o = shift_bit;
      end
      default: begin
        res_o  = logic_res;
        flag_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/vm_reg_alu_chk.sv
module vm_reg_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] y_i,
  input logic [2:0]       op_i,
  input logic             swap_i,
  input logic [WIDTH-1:0] res_o,
  input logic             flag_o
);

  logic [WIDTH-1:0] minu;
  logic [WIDTH-1:0] subt;

  always_comb begin
    minu = swap_i ? y_i : x_i;
    subt = swap_i ? x_i : y_i;
  end

  always_comb begin
    // R1
    copy_pass_chk: assert (op_i != 3'd0 || (res_o == y_i && !flag_o));
    // R2
    logic_flag_chk: assert (op_i > 3'd3 || !flag_o);
    // R3
    add_carry_chk: assert (op_i != 3'd4 ||
                           {flag_o, res_o} == {1'b0, x_i} + {1'b0, y_i});
    // R4 R5
    sub_wrap_chk: assert (op_i != 3'd5 || res_o + subt == minu);
    // R4 R5
    sub_flag_chk: assert (op_i != 3'd5 || flag_o == (minu >= subt));
    // R6
    shr_bit_chk: assert (op_i != 3'd6 ||
                         (x_i == {res_o[WIDTH-2:0], flag_o} && !res_o[WIDTH-1]));
    // R7
    shl_bit_chk: assert (op_i != 3'd7 ||
                         (x_i == {flag_o, res_o[WIDTH-1:1]} && !res_o[0]));
  end

endmodule

bind vm_reg_alu vm_reg_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .x_i    (x_i),
  .y_i    (y_i),
  .op_i   (op_i),
  .swap_i (swap_i),
  .res_o  (res_o),
  .flag_o (flag_o)
);

// File: tb/tb_vm_reg_alu.sv
`timescale 1ns/1ps
module tb_vm_reg_alu;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [2:0]   op;
  logic         swap;
  logic [W-1:0] res;
  logic         flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  vm_reg_alu #(.WIDTH(W)) dut (
    .x_i(x), .y_i(y), .op_i(op), .swap_i(swap), .res_o(res), .flag_o(flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] edges [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h55, 8'hAA};

  task automatic check(input string req, input logic [W-1:0] er,
                       input logic ef);
    n_checks++;
    if (res !== er || flag !== ef) begin
      n_fail++;
      $display("FAIL %s: op=%0d swap=%0b x=%h y=%h got res=%h flag=%0b exp res=%h flag=%0b",
               req, op, swap, x, y, res, flag, er, ef);
    end
  endtask

  // Inputs change at the falling edge, outputs sampled 2 ns later
  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] yb,
                       input logic [2:0] o, input logic s);
    @(negedge clk);
    x = xa; y = yb; op = o; swap = s;
    #2;
  endtask

  task automatic model(input logic [W-1:0] xa, input logic [W-1:0] yb,
                       input int o, input bit s,
                       output logic [W-1:0] er, output logic ef);
    int a, b, t;
    a = int'(xa); b = int'(yb);
    ef = 1'b0;
    case (o)
      0: er = yb;
      1: er = xa | yb;
      2: er = xa & yb;
      3: er = xa ^ yb;
      4: begin t = a + b; er = W'(t % 256); ef = (t > 255); end
      5: begin
           if (s) begin t = b; b = a; a = t; end
           er = W'((a - b + 256) % 256); ef = (a >= b);
         end
      6: begin er = W'(a / 2); ef = xa[0]; end
      default: begin er = W'((a * 2) % 256); ef = xa[W-1]; end
    endcase
  endtask

  task automatic t_reset_state;
    drive(8'h00, 8'h00, 3'd0, 1'b0);
    check("R1 idle", 8'h00, 1'b0);
  endtask

  task automatic t_corners;
    drive(8'hFF, 8'h01, 3'd4, 1'b0); check("R3 FF+01", 8'h00, 1'b1);
    drive(8'h7F, 8'h01, 3'd4, 1'b0); check("R3 7F+01", 8'h80, 1'b0);
    drive(8'h00, 8'h01, 3'd5, 1'b0); check("R4 00-01", 8'hFF, 1'b0);
    drive(8'h42, 8'h42, 3'd5, 1'b0); check("R4 equal", 8'h00, 1'b1);
    drive(8'h10, 8'h30, 3'd5, 1'b1); check("R5 30-10", 8'h20, 1'b1);
    drive(8'h30, 8'h10, 3'd5, 1'b1); check("R5 10-30", 8'hE0, 1'b0);
    drive(8'h81, 8'h00, 3'd6, 1'b0); check("R6 81>>1", 8'h40, 1'b1);
    drive(8'h80, 8'h00, 3'd7, 1'b0); check("R7 80<<1", 8'h00, 1'b1);
    drive(8'h55, 8'hAA, 3'd1, 1'b0); check("R2 or", 8'hFF, 1'b0);
    drive(8'h55, 8'hAA, 3'd2, 1'b0); check("R2 and", 8'h00, 1'b0);
    drive(8'h55, 8'hFF, 3'd3, 1'b0); check("R2 xor", 8'hAA, 1'b0);
    drive(8'h12, 8'h34, 3'd0, 1'b0); check("R1 copy", 8'h34, 1'b0);
  endtask

  task automatic t_sweep;
    logic [W-1:0] er;
    logic         ef;
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          model(edges[i], edges[j], o, 1'b0, er, ef);
          drive(edges[i], edges[j], 3'(o), 1'b0);
          check(o == 5 ? "R4 sweep" : "R1/R2/R3/R6/R7 sweep", er, ef);
        end
  endtask

  task automatic t_swap_ignored;
    logic [W-1:0] er;
    logic         ef;
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++) begin
        model(edges[i], edges[7-i], o, 1'b1, er, ef);
        drive(edges[i], edges[7-i], 3'(o), 1'b1);
        check(o == 5 ? "R5 swap sweep" : "R8 swap ignored", er, ef);
      end
  endtask

  task automatic t_no_clock;
    // R9: change inputs mid-cycle, away from any edge, and read at once
    @(posedge clk); #1;
    x = 8'h20; y = 8'h05; op = 3'd4; swap = 1'b0;
    #1;
    check("R9 combinational", 8'h25, 1'b0);
  endtask

  initial begin
    x = '0; y = '0; op = '0; swap = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_corners();
    t_sweep();
    t_swap_ignored();
    t_no_clock();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule